// File: doc/BRIEF.md
# Deadline Compare Timer

This block raises an interrupt request when a free-running 64-bit timestamp reaches a software-chosen point in time. Software writes an absolute deadline value into a register. On every clock the block compares the timestamp input against that value, unsigned and with greater-or-equal. When the condition is met, the block raises a single request. The request carries an 8-bit vector taken from a control word. At the same moment the block clears the deadline register to zero. A deadline written in the past therefore fires straight away, and writing zero cancels a pending deadline.

The control word holds the vector and a two-bit timer-mode field. The comparator is armed only while that field selects deadline mode and the deadline register is non-zero. The request output stays high until an end-of-interrupt pulse arrives. A second firing that occurs while a request is still outstanding merges into that request.

A build-time capability parameter decides whether the deadline function exists. When it is absent, the capability output is low, deadline writes are dropped and the request never rises. The reset input is asynchronous and active-low. Inside the block it is released synchronously through a short flop chain.

Top module: `dlt_timer`

## Requirements
- R1: Once reset has been released, the request output is low, and both the deadline register and the control word read back as zero.
- R2: The control word keeps the vector in bits [7:0] and the timer mode in bits [17:16]. The mode codes are 00 one-shot, 01 periodic and 10 deadline. A read of the control word returns only these fields, with every other bit read as zero.
- R3: Call T the timestamp value presented during the write cycle and D the written deadline. The request is first seen high after the clock edge at which the timestamp input equals max(T+1, D) + 1. The compare is unsigned greater-or-equal, so any deadline at or before the current time fires at once.
- R4: The vector output shows the control-word vector that was in effect when the request fired. A later firing replaces it.
- R5: After a firing, the deadline register reads zero.
- R6: A deadline fires only once. After the end-of-interrupt pulse, the request stays low until a new deadline is written.
- R7: Writing zero to the deadline register disarms the block, and no request follows.
- R8: A deadline write is dropped unless the mode field selects deadline mode. The register keeps reading zero and no request follows.
- R9: Writing a control word whose mode is not deadline clears the deadline register. Returning to deadline mode afterwards does not revive the cleared deadline.
- R10: The request stays high until an end-of-interrupt pulse arrives. A firing that coincides with that pulse, or that happens while the request is high, leaves a single request high.
- R11: The capability output reflects the build-time capability parameter. When the capability is absent, the deadline register reads zero and the request never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tstamp_i | input | 64 | Free-running timestamp |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 deadline, 1 control word |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for the selected register |
| eoi_i | input | 1 | End-of-interrupt pulse |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 8 | Vector of the outstanding request |
| cap_o | output | 1 | Deadline capability present |

## Verification
The bench sweeps the deadline offset relative to the live timestamp from three cycles in the past to eight cycles ahead. It uses a different vector at each step. This separates the past, equal and future cases of the compare and pins down the exact firing edge. A timestamp start value just below a 32-bit boundary makes sure a truncated compare would miscompare. Further patterns write zero, write while a non-deadline mode is selected, leave deadline mode while armed, and fire again while a request is outstanding or in the same cycle as the end-of-interrupt pulse. Each of these tells disarming, merging and clearing apart from plain firing. A second instance built without the capability receives the same stimulus and must stay silent.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int VEC_W    = 8;
  localparam int MODE_LSB = 16;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    TMODE_ONESHOT  = 2'b00,
    TMODE_PERIODIC = 2'b01,
    TMODE_DEADLINE = 2'b10,
    TMODE_RSVD     = 2'b11
  } tmode_e;

  localparam logic SEL_DEADLINE = 1'b0;
  localparam logic SEL_CTRL     = 1'b1;
endpackage

// File: rtl/dlt_rst_sync.sv
module dlt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dlt_regs.sv
module dlt_regs
  import dlt_pkg::*;
#(
  parameter int TS_W         = 64,
  parameter bit HAS_DEADLINE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [TS_W-1:0]  wdata_i,
  input  logic             fire_i,
  output logic [TS_W-1:0]  deadline_o,
  output tmode_e           mode_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

  logic       wr_ctrl, wr_dl;
  tmode_e     wmode;
  tmode_e     mode_q, mode_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic       unused_wbits;

  assign wr_ctrl = we_i && (sel_i == SEL_CTRL);
  assign wr_dl   = we_i && (sel_i == SEL_DEADLINE);
  assign wmode   = tmode_e'(wdata_i[MODE_MSB:MODE_LSB]);
  assign unused_wbits = ^{wdata_i[TS_W-1:MODE_MSB+1], wdata_i[MODE_LSB-1:VEC_W]};

  // control word: next state
  always_comb begin
    mode_d = mode_q;
    vec_d  = vec_q;
    if (wr_ctrl) begin
      mode_d = wmode;
      vec_d  = wdata_i[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TMODE_ONESHOT;
      vec_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= mode_d;
      vec_q  <= vec_d;
    end
  end

  assign mode_o = mode_q;
  assign vec_o  = vec_q;

  generate
    if (HAS_DEADLINE) begin : g_deadline
      logic [TS_W-1:0] dl_q, dl_d;
      logic            dl_en;

      always_comb begin
        dl_d = dl_q;
        if (fire_i)
          dl_d = '0;
        if (wr_ctrl && (wmode != TMODE_DEADLINE))
          dl_d = '0;
        if (wr_dl && (mode_q == TMODE_DEADLINE))
          dl_d = wdata_i;
      end

      assign dl_en = fire_i || wr_ctrl || wr_dl;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    dl_q <= '0;
        else if (dl_en) dl_q <= dl_d;
      end

      assign deadline_o = dl_q;

      // R5
      fire_clears_dl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && !wr_dl) |=> (deadline_o == '0));

      // R9
      mode_leave_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctrl && (wmode != TMODE_DEADLINE) && !wr_dl) |=> (deadline_o == '0));
    end else begin : g_no_deadline
      assign deadline_o = '0;
    end
  endgenerate
endmodule

// File: rtl/dlt_cmp.sv
module dlt_cmp
  import dlt_pkg::*;
#(
  parameter int TS_W         = 64,
  parameter bit HAS_DEADLINE = 1'b1
) (
  input  logic [TS_W-1:0] tstamp_i,
  input  logic [TS_W-1:0] deadline_i,
  input  tmode_e          mode_i,
  output logic            fire_o
);
  logic armed;
  logic reached;

  always_comb begin
    armed   = HAS_DEADLINE && (mode_i == TMODE_DEADLINE) && (deadline_i != '0);
    reached = (tstamp_i >= deadline_i);
    fire_o  = armed && reached;
  end
endmodule

// File: rtl/dlt_irq.sv
module dlt_irq
  import dlt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             eoi_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             pend_q, pend_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    pend_d = fire_i | (pend_q & ~eoi_i);
    vec_d  = fire_i ? vec_i : vec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (fire_i) vec_q <= vec_d;
  end

  assign irq_o = pend_q;
  assign vec_o = vec_q;

  // R10
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_i) |=> irq_o);

  // R10
  eoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !fire_i) |=> !irq_o);

  // R4
  fire_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (irq_o && (vec_o == $past(vec_i))));
endmodule

// File: rtl/dlt_timer.sv
module dlt_timer
  import dlt_pkg::*;
#(
  parameter int TS_W         = 64,
  parameter bit HAS_DEADLINE = 1'b1,
  parameter int RST_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-1:0]  tstamp_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [TS_W-1:0]  reg_wdata_i,
  output logic [TS_W-1:0]  reg_rdata_o,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             cap_o
);
  logic             rst_sync_n;
  logic [TS_W-1:0]  deadline;
  tmode_e           mode;
  logic [VEC_W-1:0] ctrl_vec;
  logic             fire;
  logic [TS_W-1:0]  ctrl_rd;

  dlt_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  dlt_regs #(.TS_W(TS_W), .HAS_DEADLINE(HAS_DEADLINE)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .fire_i     (fire),
    .deadline_o (deadline),
    .mode_o     (mode),
    .vec_o      (ctrl_vec)
  );

  dlt_cmp #(.TS_W(TS_W), .HAS_DEADLINE(HAS_DEADLINE)) u_cmp (
    .tstamp_i   (tstamp_i),
    .deadline_i (deadline),
    .mode_i     (mode),
    .fire_o     (fire)
  );

  dlt_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .fire_i (fire),
    .eoi_i  (eoi_i),
    .vec_i  (ctrl_vec),
    .irq_o  (irq_o),
    .vec_o  (irq_vec_o)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[VEC_W-1:0] = ctrl_vec;
    ctrl_rd[MODE_LSB +: MODE_W] = mode;
    reg_rdata_o = (reg_sel_i == SEL_CTRL) ? ctrl_rd : deadline;
  end

  assign cap_o = HAS_DEADLINE;

  // R8
  rise_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(irq_o) |-> ($past(mode) == TMODE_DEADLINE));

  // R11
  nocap_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !HAS_DEADLINE |-> !irq_o);
endmodule

// File: tb/dlt_timer_bench.sv
module dlt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tsc = 64'h0000_0001_FFFF_FF00;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [63:0] wdata = '0;
  logic        eoi = 1'b0;
  logic [63:0] rdata, rdata_nc;
  logic        irq, irq_nc, cap, cap_nc;
  logic [7:0]  vec, vec_nc;
  int          nchk = 0;
  int          nfail = 0;
  int          cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    tsc <= tsc + 64'd1;
    cyc <= cyc + 1;
  end

  dlt_timer u_dlt_timer (
    .clk_i(clk), .rst_ni(rst_n), .tstamp_i(tsc), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eoi_i(eoi), .irq_o(irq),
    .irq_vec_o(vec), .cap_o(cap));

  dlt_timer #(.HAS_DEADLINE(1'b0)) u_dlt_timer_nocap (
    .clk_i(clk), .rst_ni(rst_n), .tstamp_i(tsc), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_nc), .eoi_i(eoi), .irq_o(irq_nc),
    .irq_vec_o(vec_nc), .cap_o(cap_nc));

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 100000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [63:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [1:0] mode, input logic [7:0] v);
    wr(1'b1, {46'd0, mode, 8'd0, v});
  endtask

  // write deadline relative to the timestamp seen in the write cycle
  task automatic wr_rel(input longint off, output logic [63:0] t, output logic [63:0] d);
    @(negedge clk);
    t = tsc;
    d = tsc + 64'(off);
    we = 1'b1; sel = 1'b0; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [63:0] d, output logic [63:0] dnc);
    sel = s;
    #1;
    d = rdata;
    dnc = rdata_nc;
  endtask

  task automatic pulse_eoi();
    @(negedge clk);
    eoi = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, {63'd0, irq}, 64'd0);
    end
  endtask

  initial begin
    logic [63:0] t, d, r, rnc, exp_ts;
    int          w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    rd(1'b0, r, rnc); chk("R1 deadline", r, 64'd0);
    rd(1'b1, r, rnc); chk("R1 ctrl", r, 64'd0);
    // R11 capability
    chk("R11 cap", {63'd0, cap}, 64'd1);
    chk("R11 cap absent", {63'd0, cap_nc}, 64'd0);

    // R2 field layout, other bits dropped
    wr(1'b1, 64'hFFFF_FFFF_FFFD_12AB);
    rd(1'b1, r, rnc); chk("R2 ctrl readback", r, 64'h0000_0000_0001_00AB);

    // R8 deadline write ignored outside deadline mode
    wr_rel(-2, t, d);
    rd(1'b0, r, rnc); chk("R8 deadline ignored", r, 64'd0);
    idle(10, "R8 no irq");

    // R3/R4/R5/R6/R10 sweep over deadline offsets
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      longint off;
      v = 8'hEF - 8'(i);
      off = longint'(i) - 3;
      wr_ctrl(2'b10, v);
      rd(1'b1, r, rnc); chk("R2 ctrl mode", r, {46'd0, 2'b10, 8'd0, v});
      wr_rel(off, t, d);
      exp_ts = ((t + 64'd1) > d) ? (t + 64'd2) : (d + 64'd1);
      w = 0;
      while (!irq && w < 30) begin
        @(negedge clk);
        w++;
      end
      chk("R3 irq raised", {63'd0, irq}, 64'd1);
      chk("R3 firing time", tsc, exp_ts);
      chk("R4 vector", {56'd0, vec}, {56'd0, v});
      rd(1'b0, r, rnc); chk("R5 deadline cleared", r, 64'd0);
      repeat (3) @(negedge clk);
      chk("R10 held until eoi", {63'd0, irq}, 64'd1);
      pulse_eoi();
      chk("R10 eoi clears", {63'd0, irq}, 64'd0);
      idle(4, "R6 single firing");
      chk("R11 nocap silent", {63'd0, irq_nc}, 64'd0);
    end

    // R7 zero disarms
    wr_ctrl(2'b10, 8'h21);
    wr_rel(30, t, d);
    rd(1'b0, r, rnc); chk("R7 armed value", r, d);
    wr(1'b0, 64'd0);
    idle(40, "R7 no irq after zero");

    // R9 leaving deadline mode clears deadline
    wr_rel(10, t, d);
    wr_ctrl(2'b00, 8'h21);
    rd(1'b0, r, rnc); chk("R9 deadline cleared", r, 64'd0);
    idle(20, "R9 no irq");
    wr_ctrl(2'b10, 8'h21);
    idle(20, "R9 no revival");

    // R10 merge: fire while pending and coinciding with eoi
    wr_ctrl(2'b10, 8'h3C);
    wr_rel(-1, t, d);
    @(negedge clk);
    chk("R10 first fire", {63'd0, irq}, 64'd1);
    wr_ctrl(2'b10, 8'h4D);
    wr_rel(-1, t, d);
    eoi = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eoi = 1'b0;
    chk("R10 fire wins over eoi", {63'd0, irq}, 64'd1);
    chk("R4 vector replaced", {56'd0, vec}, 64'h4D);
    pulse_eoi();
    chk("R10 merged cleared", {63'd0, irq}, 64'd0);
    idle(4, "R10 single merged request");

    // R11 capability absent: writes dropped, never fires
    wr_rel(1000, t, d);
    rd(1'b0, r, rnc);
    chk("R11 main holds deadline", r, d);
    chk("R11 nocap deadline zero", rnc, 64'd0);
    wr_rel(-1, t, d);
    repeat (5) @(negedge clk);
    chk("R11 main fired", {63'd0, irq}, 64'd1);
    chk("R11 nocap no irq", {63'd0, irq_nc}, 64'd0);
    pulse_eoi();

    summary();
  end
endmodule